// File: doc/BRIEF.md
# Receive Character Buffer with Switchable Depth

This block is the receive-side store of a serial port. Each incoming character arrives as a data byte with a few error bits. In queue mode the block keeps up to `DEPTH` of these entries, 16 by default. In single mode it keeps exactly one, like a plain holding register. Storage is a circular array addressed by a read pointer and an occupancy count. A new character goes into the slot at `(pointer + count)` taken modulo the active depth.

Software reads the entry at the head of the buffer by pulsing the read strobe. The block reports empty, full and room-available status. It also holds a level-type receive interrupt request that turns on when the count climbs to the trigger level and turns off when a read leaves the count one below it. Changing the mode select empties the buffer, and so does the explicit flush input.

Top module: `rx_hold_fifo`

## Requirements
- R1: After reset the buffer is in single mode and `empty`=1, `full`=0, `can_accept`=1, `rx_irq`=0.
- R2: In queue mode (`fifo_en` held at 1 for at least one cycle) the buffer takes 16 entries and returns them in arrival order. `full`=1 and `can_accept`=0 exactly when it holds 16.
- R3: In single mode (`fifo_en` held at 0) one entry makes `full`=1 and `can_accept`=0.
- R4: A push while full is discarded. Count, flags and stored entries are unchanged.
- R5: `rd_entry` shows the head entry as `{error bits, data byte}`, with the data in bits [7:0] and the error bits in [11:8]. A read strobe with a non-empty buffer removes the head at the clock edge. `empty` rises when the count reaches zero.
- R6: A read strobe on an empty buffer changes neither the pointer nor the count, and `rd_entry` keeps the entry at the current pointer.
- R7: `rx_irq` becomes 1 after a push that makes the count equal to the trigger level (1).
- R8: `rx_irq` becomes 0 after a read that leaves the count at trigger−1 (0). This includes a read of an already empty buffer.
- R9: A change of `fifo_en` empties the buffer (`empty`=1, `full`=0, pointer to slot 0) and leaves `rx_irq` unchanged. The new depth applies from the next cycle.
- R10: `flush`=1 empties the buffer in the same way and leaves `rx_irq` unchanged.
- R11: A push and a read in the same cycle both take effect. The count is unchanged, the head advances, and the new entry is queued.
- R12: A push or read in a cycle in which the buffer is emptied by `flush` or a mode change is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push | input | 1 | Received character valid |
| push_data | input | DW | Received data byte |
| push_err | input | EW | Error bits received with the byte |
| rd_strobe | input | 1 | Data-register read |
| fifo_en | input | 1 | 1 = queue mode, 0 = single mode |
| flush | input | 1 | Empty the buffer |
| rd_entry | output | DW+EW | Head entry `{err, data}` |
| full | output | 1 | Count equals active depth |
| empty | output | 1 | Count is zero |
| can_accept | output | 1 | Count below active depth |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
A push and a read can land in the same cycle, and either one can coincide with a flush or a mode change. The random phase draws push, read, flush and mode-select changes independently from a fixed seed, so these overlaps occur many times. Directed steps aim them at the full, single-entry and trigger-level counts. Every cycle, a reference model in the bench is advanced from the requirements alone, and the status flags, the interrupt level and the head entry are compared with that model.

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int EW    = 4,
  parameter int TRIG  = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [DW-1:0]      push_data,
  input  logic [EW-1:0]      push_err,
  input  logic               rd_strobe,
  input  logic               fifo_en,
  input  logic               flush,
  output logic [DW+EW-1:0]   rd_entry,
  output logic               full,
  output logic               empty,
  output logic               can_accept,
  output logic               rx_irq
);
  localparam int WW = DW + EW;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WW-1:0] mem [DEPTH];
  logic [PW-1:0] pos;
  logic [CW-1:0] count;
  logic          en_q;
  logic          irq_q;

  wire [CW-1:0] depth_eff = en_q ? CW'(DEPTH) : CW'(1);
  wire [PW-1:0] mask      = en_q ? PW'(DEPTH - 1) : '0;
  wire          clear_all = flush || (fifo_en != en_q);
  wire          pop_ok    = rd_strobe && (count != '0) && !clear_all;
  wire          push_ok   = push && can_accept && !clear_all;
  wire [PW-1:0] wr_slot   = (pos + PW'(count)) & mask;
  wire [CW-1:0] cnt_after = count - CW'(pop_ok);
  wire [CW-1:0] cnt_next  = cnt_after + CW'(push_ok);
  wire          irq_clr   = rd_strobe && !clear_all && (32'(cnt_after) + 1 == TRIG);
  wire          irq_set   = push_ok && (32'(cnt_next) == TRIG);

  assign can_accept = count < depth_eff;
  assign full       = count == depth_eff;
  assign empty      = count == '0;
  assign rd_entry   = mem[pos];
  assign rx_irq     = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos   <= '0;
      count <= '0;
      en_q  <= 1'b0;
      irq_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      en_q <= fifo_en;
      if (clear_all) begin
        pos   <= '0;
        count <= '0;
      end else begin
        if (push_ok) mem[wr_slot] <= {push_err, push_data};
        if (pop_ok)  pos <= (pos + 1'b1) & mask;
        count <= cnt_next;
        if (irq_set)      irq_q <= 1'b1;
        else if (irq_clr) irq_q <= 1'b0;
      end
    end
  end

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !rd_strobe && !clear_all) |=> full);

  a_r9_mode_change_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en != en_q) |=> (empty && !full));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

  a_r7_irq_on_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !rd_strobe && !clear_all && can_accept && (32'(count) + 1 == TRIG)) |=> rx_irq);

  a_r6_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_strobe && !push && !clear_all) |=> (empty && $stable(rd_entry)));

  a_r5_last_pop_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(1) && rd_strobe && !push && !clear_all) |=> empty);

  a_r12_flush_drops_push: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_all && push) |=> empty);
endmodule

// File: tb/test_rx_hold_fifo.sv
module test_rx_hold_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int TRIG = 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        push, rd_strobe, fifo_en, flush;
  logic [7:0]  push_data;
  logic [3:0]  push_err;
  logic [11:0] rd_entry;
  logic        full, empty, can_accept, rx_irq;

  int checks = 0;
  int errors = 0;

  logic [11:0] m_mem [DEPTH];
  int          m_pos, m_cnt;
  bit          m_en, m_irq;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_hold_fifo i_rx_hold_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data), .push_err(push_err),
    .rd_strobe(rd_strobe), .fifo_en(fifo_en), .flush(flush), .rd_entry(rd_entry),
    .full(full), .empty(empty), .can_accept(can_accept), .rx_irq(rx_irq)
  );

  function automatic int m_depth();
    return m_en ? DEPTH : 1;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "empty", int'(empty), int'(m_cnt == 0));
    check(tag, "full", int'(full), int'(m_cnt == m_depth()));
    check(tag, "can_accept", int'(can_accept), int'(m_cnt < m_depth()));
    check(tag, "rx_irq", int'(rx_irq), int'(m_irq));
    check(tag, "rd_entry", int'(rd_entry), int'(m_mem[m_pos]));
  endtask

  task automatic model_step(bit p, bit r, bit e, bit f, logic [11:0] val);
    int dep, after;
    bit pop, pok;
    dep = m_depth();
    if (f || (e != m_en)) begin
      m_cnt = 0;
      m_pos = 0;
    end else begin
      pop = r && (m_cnt > 0);
      pok = p && (m_cnt < dep);
      if (pok) m_mem[(m_pos + m_cnt) & (dep - 1)] = val;
      after = m_cnt - int'(pop);
      if (pop) m_pos = (m_pos + 1) & (dep - 1);
      m_cnt = after + int'(pok);
      if (pok && m_cnt == TRIG) m_irq = 1'b1;
      else if (r && after + 1 == TRIG) m_irq = 1'b0;
    end
    m_en = e;
  endtask

  task automatic step(string tag, bit p, bit r, bit e, bit f, logic [7:0] d, logic [3:0] er);
    push = p; rd_strobe = r; fifo_en = e; flush = f; push_data = d; push_err = er;
    @(posedge clk);
    model_step(p, r, e, f, {er, d});
    @(negedge clk);
    push = 1'b0; rd_strobe = 1'b0; flush = 1'b0;
    check_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit e;
    void'($urandom(32'd1234));
    rst_n = 1'b0; push = 0; rd_strobe = 0; fifo_en = 0; flush = 0; push_data = 0; push_err = 0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    m_pos = 0; m_cnt = 0; m_en = 0; m_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    step("R9", 0, 0, 1, 0, 8'h00, 4'h0);
    for (int i = 0; i < DEPTH; i++) begin
      step((i == 0) ? "R7" : "R2", 1, 0, 1, 0, 8'(8'h30 + i), 4'(i));
    end
    check("R2", "full at 16", int'(full), 1);
    step("R4", 1, 0, 1, 0, 8'hEE, 4'hF);
    for (int i = 0; i < DEPTH; i++) begin
      check("R5", "head order", int'(rd_entry), int'({4'(i), 8'(8'h30 + i)}));
      step((i == DEPTH - 1) ? "R8" : "R5", 0, 1, 1, 0, 8'h00, 4'h0);
    end
    step("R6", 0, 1, 1, 0, 8'h00, 4'h0);
    step("R7", 1, 0, 1, 0, 8'hA1, 4'h2);
    step("R11", 1, 1, 1, 0, 8'hA2, 4'h3);
    step("R11", 1, 1, 1, 0, 8'hA3, 4'h4);
    step("R10", 0, 0, 1, 1, 8'h00, 4'h0);
    step("R8", 0, 1, 1, 0, 8'h00, 4'h0);
    step("R12", 1, 1, 1, 1, 8'h55, 4'h1);
    step("R9", 1, 0, 0, 0, 8'h66, 4'h1);
    step("R3", 1, 0, 0, 0, 8'h77, 4'h2);
    step("R4", 1, 0, 0, 0, 8'h88, 4'h3);
    step("R11", 1, 1, 0, 0, 8'h99, 4'h4);
    step("R5", 0, 1, 0, 0, 8'h00, 4'h0);
    step("R6", 0, 1, 0, 0, 8'h00, 4'h0);

    e = 1'b1;
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(99) < 2) e = ~e;
      step("R11", ($urandom_range(99) < 50), ($urandom_range(99) < 40), e,
           ($urandom_range(99) < 1), 8'($urandom), 4'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule